// File: doc/BRIEF.md
# Post-Trigger Capture Sequencer

This block records a burst of channel activity once a trigger has fired. After the trigger, it stores one snapshot of the four channel inputs per write cycle into an on-chip memory of 256 words, each 8 bits wide. When the last word has been written it raises a ready flag and stops. A host then reads the stored words back. It loads a read address and then reads the word at that address, using two active-low strobes and a separate 8-bit address/data path.

Samples are paced by a sample tick rather than by a second clock. With the select input high, the tick comes from an internal divider that sets the slow internal sampling rate. With the select input low, the tick comes from the synchronised rising edges of an external sampling clock. Each stored sample uses three tick phases: an idle phase in which the channels are latched, a chip-enable phase, and a write-strobe phase. The resulting write rate is one third of the tick rate.

Top module: `capture_sequencer`

## Requirements
- R1: After a synchronous reset, `mem_addr` is 0 and `mem_ce`, `mem_we`, `ready` and `host_ad_oe` are all low.
- R2: Until a trigger has been seen, `mem_ce` and `mem_we` stay low.
- R3: A `trig` pulse one clock long is latched and starts a full run of exactly 256 stored samples.
- R4: Each sample goes through three phases of one tick each: idle, then `mem_ce` high alone, then `mem_ce` and `mem_we` both high. Successive rises of `mem_we` are therefore exactly three ticks apart.
- R5: The first sample goes to address 0. `mem_addr` then rises by exactly one after each completed write, and no address is skipped or repeated.
- R6: Each stored word is `{4'b0000, ch}`, where `ch` is sampled on the tick that enters the chip-enable phase. Channel bit i is stored in data bit i, and bits 7:4 are zero.
- R7: When the write to address 255 completes, `ready` goes high, `mem_addr` stays at 255, and `mem_ce` and `mem_we` go low and stay low.
- R8: `ready` stays high until the next reset, and `trig` pulses while it is high start no further writes.
- R9: With `int_sel` high, a tick occurs every `INT_DIV` clocks. With `int_sel` low, a tick occurs once per rising edge of `ext_clk`, after a two-stage synchroniser.
- R10: With `rd_mode` high, a falling edge of `host_wr_n` loads `host_ad_i` as the read address.
- R11: With `rd_mode` high, while `host_rd_n` is held low, `host_ad_oe` is high and `host_ad_o` shows the word at the read address within four clocks.
- R12: With `rd_mode` low, the host strobes are ignored. `host_ad_oe` stays low and the read address keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| int_sel | input | 1 | 1: internal divider paces samples, 0: external sampling clock |
| ext_clk | input | 1 | External sampling clock (asynchronous) |
| trig | input | 1 | Trigger-fired pulse |
| ch | input | 4 | Channel inputs to record |
| rd_mode | input | 1 | 1: host read phase enabled |
| host_rd_n | input | 1 | Active-low host read strobe |
| host_wr_n | input | 1 | Active-low host address-load strobe |
| host_ad_i | input | 8 | Host address into the block |
| host_ad_o | output | 8 | Read data to the host |
| host_ad_oe | output | 1 | Drive enable for the host data bus |
| mem_addr | output | 8 | Capture memory write address |
| mem_ce | output | 1 | Capture memory chip enable |
| mem_we | output | 1 | Capture memory write strobe |
| mem_wdata | output | 8 | Word being written |
| ready | output | 1 | Memory full, capture finished |

## Verification
The bench drives the channels as a keyed function of the current write address. A sequencer that latches the channels in the wrong phase, or steps the address at the wrong moment, therefore stores words that no longer match their addresses when read back. It times the spacing between write strobes in both tick sources, which exposes a sequencer with a missing or extra phase, or a wrong divider. Other cases it covers:
- Boundary addresses 0 and 255, catching an early stop or a wrap past the end.
- A trigger pulse only one clock long, which an unlatched trigger would lose.
- Triggers after completion, which a non-sticky ready flag would turn into a second run.
- Host strobes while read mode is off, which a design that skips the mode gate would act on.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_CE   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RESET_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cap_tick_gen.sv
module cap_tick_gen #(
  parameter int unsigned INT_DIV = 408_163
) (
  input  logic clk,
  input  logic rst,
  input  logic int_sel,
  input  logic ext_clk,
  output logic tick
);
  localparam int unsigned DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             div_hit;
  logic             ext_s;
  logic             ext_prev;
  logic             ext_rise;

  cap_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_ext_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_clk),
    .q   (ext_s)
  );

  assign div_hit  = (div_cnt == DIV_LAST);
  assign ext_rise = ext_s & ~ext_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt  <= '0;
      ext_prev <= 1'b0;
      tick     <= 1'b0;
    end else begin
      div_cnt  <= div_hit ? '0 : div_cnt + 1'b1;
      ext_prev <= ext_s;
      tick     <= int_sel ? div_hit : ext_rise;
    end
  end
endmodule

// File: rtl/cap_write_fsm.sv
module cap_write_fsm
  import cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              trig,
  input  logic [CH_W-1:0]   ch,
  output logic [ADDR_W-1:0] addr,
  output logic              ce,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              ready
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam int unsigned       PAD_W     = DATA_W - CH_W;

  cap_state_e state;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;
      armed <= 1'b0;
      addr  <= '0;
      ce    <= 1'b0;
      we    <= 1'b0;
      wdata <= '0;
      ready <= 1'b0;
    end else begin
      if (trig && state != ST_DONE) armed <= 1'b1;
      case (state)
        ST_WAIT: begin
          if (armed && tick) begin
            wdata <= {{PAD_W{1'b0}}, ch};
            ce    <= 1'b1;
            state <= ST_CE;
          end
        end
        ST_CE: begin
          if (tick) begin
            we    <= 1'b1;
            state <= ST_WR;
          end
        end
        ST_WR: begin
          if (tick) begin
            we <= 1'b0;
            ce <= 1'b0;
            if (addr == LAST_ADDR) begin
              state <= ST_DONE;
              ready <= 1'b1;
              armed <= 1'b0;
            end else begin
              addr  <= addr + 1'b1;
              state <= ST_WAIT;
            end
          end
        end
        default: begin
          armed <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cap_ram.sv
module cap_ram #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cap_host_port.sv
module cap_host_port #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_mode,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] ad_i,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe
);
  logic rd_s;
  logic wr_s;
  logic wr_prev;
  logic rd_active;

  cap_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_rd_sync (
    .clk (clk), .rst (rst), .d (rd_n), .q (rd_s)
  );
  cap_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_wr_sync (
    .clk (clk), .rst (rst), .d (wr_n), .q (wr_s)
  );

  assign rd_active = rd_mode & ~rd_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b1;
      raddr   <= '0;
      ad_o    <= '0;
      ad_oe   <= 1'b0;
    end else begin
      wr_prev <= wr_s;
      if (rd_mode && wr_prev && !wr_s) raddr <= ad_i;
      ad_oe <= rd_active;
      ad_o  <= rd_active ? ram_rdata : '0;
    end
  end
endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CH_W    = 4,
  parameter int unsigned INT_DIV = 408_163
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_sel,
  input  logic              ext_clk,
  input  logic              trig,
  input  logic [CH_W-1:0]   ch,
  input  logic              rd_mode,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_ad_i,
  output logic [DATA_W-1:0] host_ad_o,
  output logic              host_ad_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ready
);
  logic              tick;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  cap_tick_gen #(.INT_DIV(INT_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .int_sel (int_sel),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  cap_write_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W)) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .trig  (trig),
    .ch    (ch),
    .addr  (mem_addr),
    .ce    (mem_ce),
    .we    (mem_we),
    .wdata (mem_wdata),
    .ready (ready)
  );

  cap_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  cap_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk       (clk),
    .rst       (rst),
    .rd_mode   (rd_mode),
    .rd_n      (host_rd_n),
    .wr_n      (host_wr_n),
    .ad_i      (host_ad_i),
    .ram_rdata (rd_data),
    .raddr     (rd_addr),
    .ad_o      (host_ad_o),
    .ad_oe     (host_ad_oe)
  );
endmodule

// File: rtl/capture_sequencer_chk.sv
module capture_sequencer_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_ce,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ready,
  input logic              host_ad_oe,
  input logic              rd_mode
);
  p_we_inside_ce_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_ce);

  p_ce_before_we_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_ce));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_addr != $past(mem_addr)) |-> (mem_addr == $past(mem_addr) + 1'b1));

  p_quiet_when_full_r7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!mem_ce && !mem_we));

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_bus_needs_mode_r12: assert property (@(posedge clk) disable iff (rst)
    host_ad_oe |-> $past(rd_mode));
endmodule

bind capture_sequencer capture_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_ce     (mem_ce),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .ready      (ready),
  .host_ad_oe (host_ad_oe),
  .rd_mode    (rd_mode)
);

// File: tb/capture_sequencer_bench.sv
`timescale 1ns/1ps
module capture_sequencer_bench;
  localparam int DIV = 4;
  localparam int EXT_HALF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       int_sel = 1'b1;
  logic       ext_clk = 1'b0;
  logic       trig = 1'b0;
  logic [3:0] ch = 4'h0;
  logic       rd_mode = 1'b0;
  logic       host_rd_n = 1'b1;
  logic       host_wr_n = 1'b1;
  logic [7:0] host_ad_i = 8'h00;
  logic [7:0] host_ad_o;
  logic       host_ad_oe;
  logic [7:0] mem_addr;
  logic       mem_ce;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic       ready;

  int  n_checks = 0;
  int  n_fail = 0;
  int  clk_cnt = 0;
  int  wcount = 0;
  int  last_rise = 0;
  int  gap = 3 * DIV;
  int  ce_seen = 0;
  bit  ext_run = 1'b0;
  bit  finished = 1'b0;
  logic [3:0] key = 4'h0;
  logic we_prev = 1'b0;

  capture_sequencer #(.INT_DIV(DIV)) u_capture_sequencer (
    .clk(clk), .rst(rst), .int_sel(int_sel), .ext_clk(ext_clk), .trig(trig),
    .ch(ch), .rd_mode(rd_mode), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_ad_i(host_ad_i), .host_ad_o(host_ad_o), .host_ad_oe(host_ad_oe),
    .mem_addr(mem_addr), .mem_ce(mem_ce), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .ready(ready)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_word(input logic [7:0] a, input logic [3:0] k);
    logic [3:0] v;
    v = 4'(a * 5) ^ a[7:4] ^ k;
    return {4'h0, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // channel driver and write monitor
  initial begin
    forever begin
      @(negedge clk);
      clk_cnt++;
      ch = exp_word(mem_addr, key)[3:0];
      if (mem_ce) ce_seen++;
      if (mem_we && !we_prev && !rst) begin
        chk(mem_addr == 8'(wcount), "R5", "write address", mem_addr, wcount);
        chk(mem_wdata == exp_word(mem_addr, key), "R6", "write data",
            mem_wdata, exp_word(mem_addr, key));
        if (wcount > 0)
          chk(clk_cnt - last_rise == gap, "R4/R9 spacing R4 R9", "strobe gap",
              clk_cnt - last_rise, gap);
        last_rise = clk_cnt;
        wcount++;
      end
      we_prev = mem_we;
    end
  end

  // external sampling clock
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (ext_run) begin
        cnt++;
        if (cnt == EXT_HALF) begin
          cnt = 0;
          ext_clk = ~ext_clk;
        end
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wcount = 0;
    we_prev = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_ready(input int limit);
    int n = 0;
    while (!ready && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(ready == 1'b1, "R7", "ready after run", ready, 1);
  endtask

  task automatic host_load(input logic [7:0] a);
    @(negedge clk);
    host_ad_i = a;
    host_wr_n = 1'b0;
    repeat (5) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(output logic [7:0] d, output logic oe);
    @(negedge clk);
    host_rd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = host_ad_o;
    oe = host_ad_oe;
    host_rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk(mem_addr == 8'h00, "R1", "addr after reset", mem_addr, 0);
    chk(!mem_ce && !mem_we, "R1", "ce/we after reset", {mem_ce, mem_we}, 0);
    chk(ready == 1'b0, "R1", "ready after reset", ready, 0);
    chk(host_ad_oe == 1'b0, "R1", "oe after reset", host_ad_oe, 0);
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    void'($urandom(32'h5EED_0C4A));

    // run 1: internal divider
    int_sel = 1'b1;
    do_reset();
    check_reset_state();
    ce_seen = 0;
    repeat (60) @(negedge clk);
    chk(ce_seen == 0, "R2", "ce without trigger", ce_seen, 0);
    key = 4'($urandom);
    gap = 3 * DIV;
    pulse_trig();
    wait_ready(20000);
    repeat (3) @(negedge clk);
    chk(wcount == 256, "R3", "samples in run", wcount, 256);
    chk(mem_addr == 8'hFF, "R7", "final addr", mem_addr, 255);

    // R8: later triggers ignored
    pulse_trig();
    repeat (80) @(negedge clk);
    chk(wcount == 256, "R8", "writes after ready", wcount, 256);
    chk(ready == 1'b1, "R8", "ready held", ready, 1);

    // R10 R11 R6: full readback
    rd_mode = 1'b1;
    for (int a = 0; a < 256; a++) begin
      host_load(8'(a));
      host_read(d, oe);
      chk(oe == 1'b1, "R11", "bus enable on read", oe, 1);
      chk(d == exp_word(8'(a), key), "R10 R6", "readback word", d, exp_word(8'(a), key));
    end

    // R12: strobes ignored with mode low
    host_load(8'd17);
    rd_mode = 1'b0;
    host_load(8'd200);
    host_read(d, oe);
    chk(oe == 1'b0, "R12", "bus enable with mode low", oe, 0);
    rd_mode = 1'b1;
    host_read(d, oe);
    chk(d == exp_word(8'd17, key), "R12", "address kept", d, exp_word(8'd17, key));

    // run 2: external sampling clock
    rd_mode = 1'b0;
    do_reset();
    check_reset_state();
    int_sel = 1'b0;
    ext_run = 1'b1;
    key = 4'($urandom);
    gap = 2 * 3 * EXT_HALF;
    repeat (20) @(negedge clk);
    pulse_trig();
    wait_ready(40000);
    repeat (3) @(negedge clk);
    chk(wcount == 256, "R3 R9", "samples in external run", wcount, 256);
    ext_run = 1'b0;
    rd_mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
      host_load(a);
      host_read(d, oe);
      chk(d == exp_word(a, key), "R6 R11", "external run readback", d, exp_word(a, key));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (clk_cnt > 150000 && !finished) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", clk_cnt);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end
endmodule